// File: doc/BRIEF.md
# Two-Mode Page Table Walker

This block turns a linear address into a physical address. It fetches one page-table entry per level from memory, starting at a root table whose base the requester supplies with each request. Pages are always 4 KB, so the low twelve bits of the address are never translated. Each request selects one of two walk formats. The short format reads 32-bit entries in two levels and covers a 32-bit linear space. The long format reads 64-bit entries in four levels and covers a 48-bit linear space.

While it walks, the block combines the permission bits of every entry it reads. The result it returns is the most restrictive combination. A walk stops early when it meets an entry that is not present. A completed walk fails if the requester asked for user or write access and some level forbids it. Only one walk is in flight at a time. The memory side is a plain read port: a request handshake, then one data beat for each read.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0 and `mem_req_valid` is 0.
- R2: With `req_long`=0 the walk makes exactly two reads. The first is at root + 4·va[31:22] and the second at table + 4·va[21:12]. The table base is entry bits [31:12] followed by twelve zeros. The physical address is the second entry's bits [31:12] followed by va[11:0]. Entry bits [63:32] and va[47:32] have no effect in this mode.
- R3: With `req_long`=1 a successful walk makes exactly four reads, each at table base + 8·index. The indices are va[47:39], va[38:30], va[29:21] and va[20:12], in that order. The next table base, and finally the page frame, come from entry bits [PA_W-1:12].
- R4: Entry bit 0 means present, bit 1 means writable and bit 2 means user-accessible. In long mode only, bit 63 means no-execute. `resp_writable` is the AND of bit 1 over all levels, `resp_user` is the AND of bit 2, and `resp_nx` is the OR of bit 63. `resp_nx` is always 0 in short mode.
- R5: If an entry has bit 0 clear, the walk ends at once with `resp_fault`=1. `resp_level` gives the failing level, counted from 0 at the root, and no further reads are made.
- R6: If a completed walk has `req_user`=1 and some level has bit 2 clear, or has `req_write`=1 and some level has bit 1 clear, it reports `resp_fault`=2 with `resp_level` set to the last level (1 or 3). Otherwise `resp_fault` is 0.
- R7: `req_ready` drops in the cycle after a request is accepted. It stays low until the response handshake completes.
- R8: `mem_req_valid` and `mem_req_addr` stay unchanged while `mem_req_ready` is low. Only one read is ever outstanding.
- R9: While `resp_valid` is 1 and `resp_ready` is 0, all response outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vaddr | input | 48 | Linear address to translate |
| req_long | input | 1 | 1 selects the four-level 64-bit format, 0 the two-level 32-bit format |
| req_root | input | PA_W | Root table base (bits [11:0] ignored) |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made at user privilege |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory (low 32 bits in short mode) |
| resp_valid | output | 1 | Translation result valid |
| resp_ready | input | 1 | Requester takes the result |
| resp_paddr | output | PA_W | Physical address (meaningful when no fault) |
| resp_writable | output | 1 | Combined write permission |
| resp_user | output | 1 | Combined user permission |
| resp_nx | output | 1 | Combined no-execute flag |
| resp_fault | output | 2 | 0 none, 1 not present, 2 protection |
| resp_level | output | 2 | Level at which the walk ended, 0 = root |

## Verification
A table of short and long walks is run against a sparse memory model. The table covers clean mappings, a read-only table in the middle of a walk, supervisor-only directories and no-execute set only at an upper level. Together these separate per-level flag folding from last-entry-only flag handling. Missing entries at the first and last levels show whether the walk stops early and reports the right level. All-ones addresses in both modes, and garbage in the upper address and entry bits in short mode, expose index slicing and masking mistakes. Directed runs stall the memory port and hold off the response to check that the handshakes stay stable and that requests stay blocked.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W     = 48;
  localparam int ENT_W    = 64;
  localparam int PG_SHIFT = 12;
  localparam int BIT_P    = 0;
  localparam int BIT_RW   = 1;
  localparam int BIT_US   = 2;
  localparam int BIT_XD   = 63;

  typedef enum logic [1:0] {
    FLT_NONE        = 2'd0,
    FLT_NOT_PRESENT = 2'd1,
    FLT_PROT        = 2'd2
  } fault_e;

  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT, ST_DONE} walk_st_e;

  // Table index for a level; long mode uses 9 bits, short mode 10 bits.
  function automatic logic [9:0] walk_index(logic [VA_W-1:0] va, logic [1:0] lvl, logic long_mode);
    if (long_mode) begin
      case (lvl)
        2'd0:    walk_index = {1'b0, va[47:39]};
        2'd1:    walk_index = {1'b0, va[38:30]};
        2'd2:    walk_index = {1'b0, va[29:21]};
        default: walk_index = {1'b0, va[20:12]};
      endcase
    end else begin
      walk_index = (lvl == 2'd0) ? va[31:22] : va[21:12];
    end
  endfunction

  // Byte offset of the entry inside its 4 KB table.
  function automatic logic [PG_SHIFT-1:0] entry_offset(logic [9:0] idx, logic long_mode);
    entry_offset = long_mode ? {idx[8:0], 3'b000} : {idx, 2'b00};
  endfunction

  function automatic logic [1:0] final_level(logic long_mode);
    final_level = long_mode ? 2'd3 : 2'd1;
  endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic [PA_W-PG_SHIFT-1:0] table_frame,
  input  logic [VA_W-1:0]          va,
  input  logic [1:0]               lvl,
  input  logic                     long_mode,
  output logic [PA_W-1:0]          entry_addr
);
  logic [9:0]          idx;
  logic [PG_SHIFT-1:0] offs;

  assign idx        = walk_index(va, lvl, long_mode);
  assign offs       = entry_offset(idx, long_mode);
  // Table is 4 KB aligned, so the offset drops into the low bits.
  assign entry_addr = {table_frame, offs};
endmodule

// File: rtl/ptw_perm_acc.sv
module ptw_perm_acc (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic upd,
  input  logic ent_rw,
  input  logic ent_us,
  input  logic ent_xd,
  output logic nxt_rw,
  output logic nxt_us,
  output logic nxt_xd,
  output logic acc_rw,
  output logic acc_us,
  output logic acc_xd
);
  assign nxt_rw = acc_rw & ent_rw;
  assign nxt_us = acc_us & ent_us;
  assign nxt_xd = acc_xd | ent_xd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_rw <= 1'b0;
      acc_us <= 1'b0;
      acc_xd <= 1'b0;
    end else if (init) begin
      acc_rw <= 1'b1;
      acc_us <= 1'b1;
      acc_xd <= 1'b0;
    end else if (upd) begin
      acc_rw <= nxt_rw;
      acc_us <= nxt_us;
      acc_xd <= nxt_xd;
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [47:0]       req_vaddr,
  input  logic              req_long,
  input  logic [PA_W-1:0]   req_root,
  input  logic              req_write,
  input  logic              req_user,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [PA_W-1:0]   resp_paddr,
  output logic              resp_writable,
  output logic              resp_user,
  output logic              resp_nx,
  output logic [1:0]        resp_fault,
  output logic [1:0]        resp_level
);
  localparam int FRAME_W = PA_W - PG_SHIFT;

  walk_st_e              st;
  logic [1:0]            lvl;
  logic [VA_W-1:0]       va_q;
  logic                  long_q, wr_q, usr_q;
  logic [FRAME_W-1:0]    frame_q;
  logic [PA_W-1:0]       pa_q;
  fault_e                fault_q;
  logic [1:0]            flvl_q;

  // Named events
  logic req_fire, mem_fire, rsp_fire, resp_fire, at_last, ent_present, prot_hit;
  logic ent_rw, ent_us, ent_xd;
  logic [FRAME_W-1:0] ent_frame;
  logic nxt_rw, nxt_us, nxt_xd;
  logic unused_bits;

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_ISSUE);
  assign resp_valid    = (st == ST_DONE);
  assign req_fire      = req_valid & req_ready;
  assign mem_fire      = mem_req_valid & mem_req_ready;
  assign rsp_fire      = mem_rsp_valid & (st == ST_WAIT);
  assign resp_fire     = resp_valid & resp_ready;
  assign at_last       = (lvl == final_level(long_q));

  assign ent_present = mem_rsp_data[BIT_P];
  assign ent_rw      = mem_rsp_data[BIT_RW];
  assign ent_us      = mem_rsp_data[BIT_US];
  assign ent_xd      = long_q & mem_rsp_data[BIT_XD];
  assign ent_frame   = long_q ? mem_rsp_data[PA_W-1:PG_SHIFT]
                              : FRAME_W'(mem_rsp_data[31:PG_SHIFT]);
  assign unused_bits = ^{mem_rsp_data[62:PA_W], req_root[PG_SHIFT-1:0]};

  ptw_addr_gen #(.PA_W(PA_W)) u_addr (
    .table_frame (frame_q),
    .va          (va_q),
    .lvl         (lvl),
    .long_mode   (long_q),
    .entry_addr  (mem_req_addr)
  );

  ptw_perm_acc u_perm (
    .clk    (clk),
    .rst_n  (rst_n),
    .init   (req_fire),
    .upd    (rsp_fire & ent_present),
    .ent_rw (ent_rw),
    .ent_us (ent_us),
    .ent_xd (ent_xd),
    .nxt_rw (nxt_rw),
    .nxt_us (nxt_us),
    .nxt_xd (nxt_xd),
    .acc_rw (resp_writable),
    .acc_us (resp_user),
    .acc_xd (resp_nx)
  );

  assign prot_hit = (usr_q & ~nxt_us) | (wr_q & ~nxt_rw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      lvl     <= '0;
      va_q    <= '0;
      long_q  <= 1'b0;
      wr_q    <= 1'b0;
      usr_q   <= 1'b0;
      frame_q <= '0;
      pa_q    <= '0;
      fault_q <= FLT_NONE;
      flvl_q  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_fire) begin
          va_q    <= req_vaddr;
          long_q  <= req_long;
          wr_q    <= req_write;
          usr_q   <= req_user;
          frame_q <= req_root[PA_W-1:PG_SHIFT];
          lvl     <= '0;
          st      <= ST_ISSUE;
        end
        ST_ISSUE: if (mem_req_ready) st <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (!ent_present) begin
            fault_q <= FLT_NOT_PRESENT;
            flvl_q  <= lvl;
            st      <= ST_DONE;
          end else if (at_last) begin
            pa_q    <= {ent_frame, va_q[PG_SHIFT-1:0]};
            fault_q <= prot_hit ? FLT_PROT : FLT_NONE;
            flvl_q  <= lvl;
            st      <= ST_DONE;
          end else begin
            frame_q <= ent_frame;
            lvl     <= lvl + 2'd1;
            st      <= ST_ISSUE;
          end
        end
        default: if (resp_fire) st <= ST_IDLE;
      endcase
    end
  end

  assign resp_paddr = pa_q;
  assign resp_fault = fault_q;
  assign resp_level = flvl_q;

  // Read counter for the checks below only
  logic [2:0] reads_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        reads_q <= '0;
    else if (req_fire) reads_q <= '0;
    else if (mem_fire) reads_q <= reads_q + 3'd1;
  end

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready);  // R7
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));  // R8
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fire |=> !mem_req_valid);  // R8
  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid &&
      $stable({resp_paddr, resp_fault, resp_level, resp_writable, resp_user, resp_nx}));  // R9
  AST_FULL_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault == FLT_NONE |-> reads_q == (long_q ? 3'd4 : 3'd2));  // R3
  AST_NP_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault == FLT_NOT_PRESENT |-> reads_q == {1'b0, resp_level} + 3'd1);  // R5
  AST_USER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault == FLT_NONE && usr_q |-> resp_user);  // R6
  AST_WRITE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_fault == FLT_NONE && wr_q |-> resp_writable);  // R6
  AST_SHORT_NO_NX: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !long_q |-> !resp_nx);  // R4
endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  localparam int PA_W = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic            req_valid = 0, req_long = 0, req_write = 0, req_user = 0;
  logic [47:0]     req_vaddr = '0;
  logic [PA_W-1:0] req_root = '0;
  logic            req_ready;
  logic            mem_req_valid, mem_req_ready;
  logic [PA_W-1:0] mem_req_addr;
  logic            mem_rsp_valid = 0;
  logic [63:0]     mem_rsp_data = '0;
  logic            resp_valid, resp_ready = 0;
  logic [PA_W-1:0] resp_paddr;
  logic            resp_writable, resp_user, resp_nx;
  logic [1:0]      resp_fault, resp_level;

  pt_walker #(.PA_W(PA_W)) uut (.*);

  // Sparse memory model
  logic [63:0] pmem [logic [39:0]];
  function automatic logic [63:0] rd(logic [39:0] a);
    return pmem.exists(a) ? pmem[a] : 64'h0;
  endfunction

  logic rdy_tog = 0, stall = 0;
  int   rd_cnt = 0;
  always @(negedge clk) rdy_tog <= ~rdy_tog;
  assign mem_req_ready = !stall && rdy_tog;
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_data  <= rd(mem_req_addr);
      rd_cnt        <= rd_cnt + 1;
    end
  end

  int checks = 0, fails = 0;
  bit done = 0;
  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  localparam logic [39:0] ROOT32 = 40'h10_0000;
  localparam logic [39:0] ROOT64 = 40'h30_0000;

  typedef struct packed {
    logic        lng;
    logic [47:0] va;
    logic        wr;
    logic        usr;
    logic [1:0]  flt;
    logic [1:0]  lvl;
    logic [39:0] pa;
    logic        frw, fus, fxd;
    logic [2:0]  reads;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 48'h0000_0040_1ABC, 1'b0, 1'b1, 2'd0, 2'd0, 40'h00_0ABC_DABC, 1'b1, 1'b1, 1'b0, 3'd2},
    '{1'b0, 48'h0000_0080_2123, 1'b0, 1'b1, 2'd0, 2'd0, 40'h00_0123_4123, 1'b0, 1'b1, 1'b0, 3'd2},
    '{1'b0, 48'h0000_0080_2123, 1'b1, 1'b0, 2'd2, 2'd1, 40'h0,            1'b0, 1'b0, 1'b0, 3'd2},
    '{1'b0, 48'h0000_00C0_3456, 1'b0, 1'b1, 2'd2, 2'd1, 40'h0,            1'b0, 1'b0, 1'b0, 3'd2},
    '{1'b0, 48'h0000_00C0_3456, 1'b1, 1'b0, 2'd0, 2'd0, 40'h00_0555_5456, 1'b1, 1'b0, 1'b0, 3'd2},
    '{1'b0, 48'h0000_0100_0000, 1'b0, 1'b0, 2'd1, 2'd0, 40'h0,            1'b0, 1'b0, 1'b0, 3'd1},
    '{1'b0, 48'h0000_0040_5000, 1'b0, 1'b0, 2'd1, 2'd1, 40'h0,            1'b0, 1'b0, 1'b0, 3'd2},
    '{1'b0, 48'h0000_FFFF_FFFF, 1'b1, 1'b1, 2'd0, 2'd0, 40'h00_FEDC_BFFF, 1'b1, 1'b1, 1'b0, 3'd2},
    '{1'b1, 48'h0080_8060_4789, 1'b1, 1'b1, 2'd0, 2'd0, 40'hF0_1234_5789, 1'b1, 1'b1, 1'b1, 3'd4},
    '{1'b1, 48'h0080_8060_50AB, 1'b0, 1'b0, 2'd1, 2'd3, 40'h0,            1'b0, 1'b0, 1'b0, 3'd4},
    '{1'b1, 48'h0100_0000_0000, 1'b0, 1'b0, 2'd1, 2'd0, 40'h0,            1'b0, 1'b0, 1'b0, 3'd1},
    '{1'b1, 48'h0180_0000_0010, 1'b0, 1'b1, 2'd0, 2'd0, 40'h00_0777_7010, 1'b0, 1'b1, 1'b1, 3'd4},
    '{1'b1, 48'h0180_0000_0010, 1'b1, 1'b0, 2'd2, 2'd3, 40'h0,            1'b0, 1'b0, 1'b0, 3'd4},
    '{1'b1, 48'hFFFF_FFFF_FFFF, 1'b0, 1'b1, 2'd0, 2'd0, 40'hAA_BBCC_DFFF, 1'b1, 1'b1, 1'b0, 3'd4},
    '{1'b0, 48'hABCD_0040_1ABC, 1'b0, 1'b0, 2'd0, 2'd0, 40'h00_0ABC_DABC, 1'b1, 1'b1, 1'b0, 3'd2}
  };

  int rd_base;
  task automatic start_walk(vec_t v);
    @(negedge clk);
    req_valid = 1; req_long = v.lng; req_vaddr = v.va;
    req_write = v.wr; req_user = v.usr;
    req_root  = v.lng ? ROOT64 : ROOT32;
    rd_base   = rd_cnt;
    chk("R7", "ready before accept", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    chk("R7", "ready after accept", req_ready, 0);
  endtask

  task automatic finish_walk(vec_t v, int hold);
    int t;
    logic [PA_W-1:0] pa0;
    logic [1:0] f0;
    t = 0;
    while (!resp_valid && t < 400) begin @(negedge clk); t++; end
    if (!resp_valid) begin
      chk("R7", "walk completion", 0, 1);
      return;
    end
    pa0 = resp_paddr; f0 = resp_fault;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R9", "valid held", resp_valid, 1);
      chk("R9", "paddr held", resp_paddr, pa0);
      chk("R9", "fault held", resp_fault, f0);
      chk("R7", "ready low while result pending", req_ready, 0);
    end
    chk(v.flt == 2'd0 ? "R6" : (v.flt == 2'd1 ? "R5" : "R6"), "fault code", resp_fault, v.flt);
    if (v.flt != 2'd0) chk(v.flt == 2'd1 ? "R5" : "R6", "fault level", resp_level, v.lvl);
    else begin
      chk(v.lng ? "R3" : "R2", "paddr", resp_paddr, v.pa);
      chk("R4", "flags rw/us/nx", {resp_writable, resp_user, resp_nx}, {v.frw, v.fus, v.fxd});
    end
    chk(v.lng ? "R3" : "R2", "read count", rd_cnt - rd_base, v.reads);
    resp_ready = 1;
    @(negedge clk);
    resp_ready = 0;
    chk("R7", "ready after response", req_ready, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R7 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // short mode tables (upper half of one directory entry holds garbage)
    pmem[40'h10_0004] = 64'hFFFF_FFFF_0020_0007;
    pmem[40'h20_0004] = 64'h0ABC_D007;
    pmem[40'h10_0008] = 64'h0020_1005;
    pmem[40'h20_1008] = 64'h0123_4007;
    pmem[40'h10_000C] = 64'h0020_2003;
    pmem[40'h20_200C] = 64'h0555_5007;
    pmem[40'h10_0FFC] = 64'h0020_F007;
    pmem[40'h20_FFFC] = 64'hFEDC_B007;
    // long mode tables
    pmem[40'h30_0008] = 64'h30_1007;
    pmem[40'h30_1010] = 64'h30_2007;
    pmem[40'h30_2018] = 64'h30_3007;
    pmem[40'h30_3020] = 64'h8000_00F0_1234_5007;
    pmem[40'h30_0018] = 64'h8000_0000_0030_4007;
    pmem[40'h30_4000] = 64'h30_5005;
    pmem[40'h30_5000] = 64'h30_6007;
    pmem[40'h30_6000] = 64'h0777_7007;
    pmem[40'h30_0FF8] = 64'h30_7007;
    pmem[40'h30_7FF8] = 64'h30_8007;
    pmem[40'h30_8FF8] = 64'h30_9007;
    pmem[40'h30_9FF8] = 64'hAA_BBCC_D007;

    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", req_ready, 1);
    chk("R1", "resp_valid in reset", resp_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "ready after reset", req_ready, 1);
    chk("R1", "resp_valid after reset", resp_valid, 0);
    chk("R1", "mem_req_valid after reset", mem_req_valid, 0);

    for (int n = 0; n < NV; n++) begin
      start_walk(VEC[n]);
      finish_walk(VEC[n], 0);
    end

    // R8: stalled memory port holds the first directory read
    stall = 1;
    start_walk(VEC[0]);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R8", "read held under stall", mem_req_valid, 1);
      chk("R8", "address held under stall", mem_req_addr, 40'h10_0004);
      chk("R7", "ready low mid-walk", req_ready, 0);
    end
    chk("R8", "no read during stall", rd_cnt - rd_base, 0);
    stall = 0;
    finish_walk(VEC[0], 0);

    // R9: result held under back-pressure
    start_walk(VEC[11]);
    finish_walk(VEC[11], 4);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule